// File: doc/BRIEF.md
# Parallel DAC Register Interface

This block is the digital front end of a 12-bit voltage DAC that hangs off an 8-bit microcontroller bus. The host writes a 12-bit code in two parts, an 8-bit low byte and a 4-bit high nibble, and a 3-bit control field. Each part has its own bus address. A write goes into one of three holding registers. A separate output register feeds the converter. It is loaded from the holding registers under an active-low load strobe, in either a transparent (asynchronous) mode or a one-shot (synchronous) mode, and the control field selects which.

The block also drives a power-down output and a speed-select output. Each is the OR of a control bit and an external pin. A read-back port returns the contents of the holding registers.

All inputs are sampled on the rising edge of `clk`. The write port has no back-pressure: every qualified write is accepted in the cycle in which it is sampled, so there is no ready signal and the host may write on back-to-back cycles.

Top module: `dacif_top`

## Requirements
- R1: After reset, all holding registers read back zero, `dac_code` is zero, and `pd_out` and `fast_out` are low while `pwd_n` is high and `spd_in` is low.
- R2: A write with `cs_n` and `we_n` both low and `bus_a` = 00 stores `bus_d` in the low-byte register at that clock edge. Read-back select 00 returns this register.
- R3: A write to address 01 stores `bus_d[3:0]` in the high-nibble register, and bits 7:4 are dropped. Read-back select 01 returns the nibble zero-extended.
- R4: A write to address 10 stores `bus_d[2:0]` in the control register, with bit 0 as the power-down request, bit 1 as fast speed and bit 2 as synchronous mode. Read-back select 10 returns the field zero-extended.
- R5: A write to address 11 changes no holding register.
- R6: While `cs_n` is high, `we_n` low changes no holding register.
- R7: While `ld_n` is high, `dac_code` holds its value, even when the holding registers change.
- R8: With control bit 2 clear, every clock edge that samples `ld_n` low loads `dac_code` with {high nibble, low byte} as they stood before that edge.
- R9: With control bit 2 set, `dac_code` loads only at the first edge that samples `ld_n` low after it was high. Later holding writes do not reach the output until the next falling transition of `ld_n`.
- R10: `pd_out` is high whenever `pwd_n` is low or control bit 0 is set.
- R11: `fast_out` is high whenever `spd_in` is high or control bit 1 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| bus_d | input | 8 | Write data bus |
| bus_a | input | 2 | Holding register address |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| ld_n | input | 1 | Load strobe for the output register, active low |
| pwd_n | input | 1 | External power-down, active low |
| spd_in | input | 1 | External fast-speed request |
| rb_sel | input | 2 | Read-back register select |
| rb_data | output | 8 | Read-back data, combinational |
| dac_code | output | 12 | Code driven to the converter |
| pd_out | output | 1 | Power-down to the analog section |
| fast_out | output | 1 | Fast-speed select to the analog section |

## Verification
A holding write sampled at one rising edge shows on `rb_data` right after that edge, because the read-back path is combinational. The bench drives on falling edges and reads back at the next falling edge. A load sampled at an edge updates `dac_code` at that same edge from the holding values before it. A write issued while `ld_n` is already low therefore reaches the output in asynchronous mode one edge after the write lands, and the checks wait that extra edge. `pd_out` and `fast_out` follow their pins in the same cycle, so they are sampled 1 ns after the pin changes.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  typedef enum logic [1:0] {
    SEL_LO   = 2'b00,
    SEL_HI   = 2'b01,
    SEL_CTL  = 2'b10,
    SEL_RSVD = 2'b11
  } dacif_sel_e;

  localparam int CTL_PD_BIT   = 0;
  localparam int CTL_FAST_BIT = 1;
  localparam int CTL_SYNC_BIT = 2;
endpackage

// File: rtl/dacif_decode.sv
module dacif_decode
  import dacif_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              cs_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_lo,
  output logic              wr_hi,
  output logic              wr_ctl
);
  logic wr_any;
  assign wr_any = !cs_n && !we_n;

  always_comb begin
    wr_lo  = 1'b0;
    wr_hi  = 1'b0;
    wr_ctl = 1'b0;
    if (wr_any) begin
      case (dacif_sel_e'(addr[1:0]))
        SEL_LO:  wr_lo  = 1'b1;
        SEL_HI:  wr_hi  = 1'b1;
        SEL_CTL: wr_ctl = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    assert ($countones({wr_lo, wr_hi, wr_ctl}) <= 1)
      else $error("decode strobes overlap");
  end
endmodule

// File: rtl/dacif_hold.sv
module dacif_hold #(
  parameter int DATA_W = 8,
  parameter int HI_W   = 4,
  parameter int CTL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_ctl,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] lo_q,
  output logic [HI_W-1:0]   hi_q,
  output logic [CTL_W-1:0]  ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      ctl_q <= '0;
    end else begin
      if (wr_lo)  lo_q  <= din;
      if (wr_hi)  hi_q  <= din[HI_W-1:0];
      if (wr_ctl) ctl_q <= din[CTL_W-1:0];
    end
  end

  assert_cs_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(lo_q) && $stable(hi_q) && $stable(ctl_q)))
    else $error("holding changed while deselected");

  assert_rsvd_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n && addr == 2'b11) |=> ($stable(lo_q) && $stable(hi_q) && $stable(ctl_q)))
    else $error("reserved address write changed holding");

  assert_lo_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n && addr == 2'b00) |=> (lo_q == $past(din)))
    else $error("low byte not captured");
endmodule

// File: rtl/dacif_update.sv
module dacif_update #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_n,
  input  logic              sync_mode,
  input  logic [CODE_W-1:0] hold_code,
  output logic [CODE_W-1:0] code_q
);
  logic ld_q;
  logic load_now;

  always_comb begin
    if (sync_mode) load_now = !ld_n && ld_q;
    else           load_now = !ld_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_q   <= 1'b1;
      code_q <= '0;
    end else begin
      ld_q <= ld_n;
      if (load_now) code_q <= hold_code;
    end
  end

  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> $stable(code_q))
    else $error("output moved without load");

  assert_async_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && !ld_n) |=> (code_q == $past(hold_code)))
    else $error("transparent load missed");

  assert_sync_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !ld_n && !ld_q) |=> $stable(code_q))
    else $error("synchronous mode reloaded while strobe held");
endmodule

// File: rtl/dacif_top.sv
module dacif_top
  import dacif_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 12,
  parameter int CTL_W  = 3,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_d,
  input  logic [ADDR_W-1:0] bus_a,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              ld_n,
  input  logic              pwd_n,
  input  logic              spd_in,
  input  logic [ADDR_W-1:0] rb_sel,
  output logic [DATA_W-1:0] rb_data,
  output logic [CODE_W-1:0] dac_code,
  output logic              pd_out,
  output logic              fast_out
);
  localparam int HI_W = CODE_W - DATA_W;

  logic              wr_lo, wr_hi, wr_ctl;
  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [CTL_W-1:0]  ctl_q;

  dacif_decode #(.ADDR_W(ADDR_W)) u_dec (
    .cs_n   (cs_n),
    .we_n   (we_n),
    .addr   (bus_a),
    .wr_lo  (wr_lo),
    .wr_hi  (wr_hi),
    .wr_ctl (wr_ctl)
  );

  dacif_hold #(.DATA_W(DATA_W), .HI_W(HI_W), .CTL_W(CTL_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .we_n   (we_n),
    .wr_lo  (wr_lo),
    .wr_hi  (wr_hi),
    .wr_ctl (wr_ctl),
    .addr   (bus_a[1:0]),
    .din    (bus_d),
    .lo_q   (lo_q),
    .hi_q   (hi_q),
    .ctl_q  (ctl_q)
  );

  dacif_update #(.CODE_W(CODE_W)) u_upd (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_n      (ld_n),
    .sync_mode (ctl_q[CTL_SYNC_BIT]),
    .hold_code ({hi_q, lo_q}),
    .code_q    (dac_code)
  );

  always_comb begin
    case (dacif_sel_e'(rb_sel[1:0]))
      SEL_LO:  rb_data = lo_q;
      SEL_HI:  rb_data = {{(DATA_W-HI_W){1'b0}}, hi_q};
      SEL_CTL: rb_data = {{(DATA_W-CTL_W){1'b0}}, ctl_q};
      default: rb_data = '0;
    endcase
  end

  assign pd_out   = ctl_q[CTL_PD_BIT]   | ~pwd_n;
  assign fast_out = ctl_q[CTL_FAST_BIT] | spd_in;

  assert_pin_powerdown_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwd_n |-> pd_out)
    else $error("power-down pin not honoured");

  assert_pin_speed_R11: assert property (@(posedge clk) disable iff (!rst_n)
    spd_in |-> fast_out)
    else $error("speed pin not honoured");
endmodule

// File: tb/tb_dacif_top.sv
module tb_dacif_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_d = '0;
  logic [1:0]  bus_a = '0;
  logic        cs_n = 1'b1, we_n = 1'b1, ld_n = 1'b1;
  logic        pwd_n = 1'b1, spd_in = 1'b0;
  logic [1:0]  rb_sel = '0;
  logic [7:0]  rb_data;
  logic [11:0] dac_code;
  logic        pd_out, fast_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dacif_top dut (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .bus_a(bus_a), .cs_n(cs_n),
    .we_n(we_n), .ld_n(ld_n), .pwd_n(pwd_n), .spd_in(spd_in),
    .rb_sel(rb_sel), .rb_data(rb_data), .dac_code(dac_code),
    .pd_out(pd_out), .fast_out(fast_out)
  );

  // fields: [20:19] addr, [18:11] data, [10] cs_n, [9:8] rb_sel, [7:0] expected
  localparam logic [20:0] VEC [9] = '{
    {2'd0, 8'hA5, 1'b0, 2'd0, 8'hA5},  // R2 low byte
    {2'd1, 8'hF7, 1'b0, 2'd1, 8'h07},  // R3 upper bits dropped
    {2'd2, 8'hFA, 1'b0, 2'd2, 8'h02},  // R4 control field
    {2'd3, 8'h33, 1'b0, 2'd0, 8'hA5},  // R5 reserved, low unchanged
    {2'd3, 8'h33, 1'b0, 2'd1, 8'h07},  // R5 reserved, high unchanged
    {2'd0, 8'h11, 1'b1, 2'd0, 8'hA5},  // R6 deselected
    {2'd1, 8'h0C, 1'b1, 2'd1, 8'h07},  // R6 deselected
    {2'd0, 8'h3C, 1'b0, 2'd0, 8'h3C},  // R2 second pattern
    {2'd2, 8'h00, 1'b0, 2'd2, 8'h00}   // R4 clear control
  };

  task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic c);
    @(negedge clk);
    bus_a = a; bus_d = d; cs_n = c; we_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 code", dac_code, 12'h000);
    chk("R1 pd", {11'b0, pd_out}, 12'h000);
    chk("R1 fast", {11'b0, fast_out}, 12'h000);
    for (int s = 0; s < 3; s++) begin
      rb_sel = 2'(s);
      #1 chk("R1 readback", {4'b0, rb_data}, 12'h000);
    end

    for (int i = 0; i < 9; i++) begin
      bus_write(VEC[i][20:19], VEC[i][18:11], VEC[i][10]);
      rb_sel = VEC[i][9:8];
      #1 chk($sformatf("vector %0d (R2..R6)", i), {4'b0, rb_data}, {4'b0, VEC[i][7:0]});
    end
    // R7 no load yet
    chk("R7 idle", dac_code, 12'h000);

    // R8 asynchronous: hold is 0x73C, control is 0
    @(negedge clk); ld_n = 1'b0;
    @(negedge clk);
    chk("R8 first load", dac_code, 12'h73C);
    bus_write(2'd0, 8'h99, 1'b0);
    @(negedge clk);
    chk("R8 follows", dac_code, 12'h799);
    ld_n = 1'b1;
    bus_write(2'd0, 8'h44, 1'b0);
    @(negedge clk);
    chk("R7 hold", dac_code, 12'h799);

    // R9 synchronous
    bus_write(2'd2, 8'h04, 1'b0);
    bus_write(2'd0, 8'h55, 1'b0);
    @(negedge clk); ld_n = 1'b0;
    @(negedge clk);
    chk("R9 edge load", dac_code, 12'h755);
    bus_write(2'd0, 8'hAA, 1'b0);
    repeat (2) @(negedge clk);
    chk("R9 no reload", dac_code, 12'h755);
    ld_n = 1'b1;
    @(negedge clk); ld_n = 1'b0;
    @(negedge clk);
    chk("R9 next edge", dac_code, 12'h7AA);
    ld_n = 1'b1;

    // R10 power-down
    pwd_n = 1'b0;
    #1 chk("R10 pin", {11'b0, pd_out}, 12'h001);
    pwd_n = 1'b1;
    #1 chk("R10 released", {11'b0, pd_out}, 12'h000);
    bus_write(2'd2, 8'h05, 1'b0);
    #1 chk("R10 control bit", {11'b0, pd_out}, 12'h001);

    // R11 speed
    chk("R11 slow", {11'b0, fast_out}, 12'h000);
    spd_in = 1'b1;
    #1 chk("R11 pin", {11'b0, fast_out}, 12'h001);
    spd_in = 1'b0;
    bus_write(2'd2, 8'h02, 1'b0);
    #1 chk("R11 control bit", {11'b0, fast_out}, 12'h001);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule